// File: doc/BRIEF.md
# Byte-Wide Parallel ADC Read Controller

This block drives a 16-bit successive-approximation converter through its parallel port when only eight data lines are wired. A conversion starts when the controller holds chip-select and read/convert low for a fixed number of clock cycles. The controller then releases both lines and waits for the converter's busy flag to rise. It then enables the port and reads the upper byte with byte-select low. Next it raises byte-select, waits a set number of cycles for the bus to settle, and reads the lower byte. The two bytes form one signed sample, which is presented with a single-cycle valid strobe.

A conversion can be requested on a start pin, or by an internal period counter when auto mode is enabled. No request is queued. A request is dropped if it arrives while a conversion is in progress, or before the minimum spacing between convert commands has passed. If busy never rises, a watchdog returns the controller to idle and sets a sticky error flag.

Top module: `adc_pbr_ctrl`

## Requirements
- R1: A conversion starts with adc_cs_n_o and adc_rc_n_o both low for exactly PULSE_CYC consecutive cycles.
- R2: After the convert pulse, adc_rc_n_o and adc_cs_n_o are both high before adc_busy_i rises, and both stay high until it does.
- R3: After busy rises, the controller drives adc_cs_n_o low with adc_byte_o low (low selects the upper eight bits). It captures the upper byte after the port has held that selection for SETTLE_CYC cycles.
- R4: The controller then drives adc_byte_o high (high selects the lower eight bits). It holds that level at least SETTLE_CYC cycles before it captures the lower byte.
- R5: sample_o equals {upper byte, lower byte} read as a signed two's complement value. sample_valid_o is high for exactly one cycle per sample, and sample_o holds its value until the next sample.
- R6: A start_i pulse or period tick during a conversion is ignored and causes no extra convert pulse afterwards.
- R7: Falling edges of adc_rc_n_o are at least GAP_CYC cycles apart. A request inside that window is dropped.
- R8: While auto_en_i is high, a conversion is requested every PERIOD_CYC cycles without start_i.
- R9: If busy does not rise within TIMEOUT_CYC cycles after the convert pulse, the controller returns to idle and timeout_err_o goes high. The flag stays high until reset, and later conversions still work.
- R10: After reset, adc_cs_n_o and adc_rc_n_o are high, adc_byte_o, sample_valid_o and timeout_err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a conversion |
| auto_en_i | input | 1 | Enable periodic conversions |
| adc_busy_i | input | 1 | Converter busy flag, low while converting |
| adc_data_i | input | 8 | Shared byte bus from the converter |
| adc_cs_n_o | output | 1 | Chip-select, active low |
| adc_rc_n_o | output | 1 | Read/convert, low starts a conversion |
| adc_byte_o | output | 1 | Byte-select: 0 upper, 1 lower |
| sample_o | output | 16 | Assembled signed sample |
| sample_valid_o | output | 1 | One-cycle strobe for a new sample |
| timeout_err_o | output | 1 | Sticky busy-timeout flag |

## Verification
A wrong sequencer state first shows on the converter pins. A convert pulse of the wrong length, or a read/convert line still low when busy rises, is visible the same cycle. A byte captured early shows within one sample: the model bus returns filler until the selection has settled, so sample_o would hold the filler. A faulty request gate or spacing counter shows as an extra or missing falling edge on read/convert. A broken watchdog shows as timeout_err_o staying low, or as the controller stuck with chip-select released and never pulsing again.

// File: rtl/adc_pbr_pkg.sv
package adc_pbr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_WAIT_BUSY,
        ST_READ_HI,
        ST_SWITCH,
        ST_READ_LO,
        ST_OUTPUT
    } pbr_state_e;

    typedef logic signed [15:0] pbr_sample_t;

    typedef struct packed {
        logic cs_n;
        logic rc_n;
        logic byte_sel;
    } pbr_pins_t;

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

    function automatic pbr_pins_t pins_for(pbr_state_e s);
        pbr_pins_t p;
        p.cs_n     = 1'b1;
        p.rc_n     = 1'b1;
        p.byte_sel = 1'b0;
        case (s)
            ST_CONV:    begin p.cs_n = 1'b0; p.rc_n = 1'b0; end
            ST_READ_HI: begin p.cs_n = 1'b0; end
            ST_SWITCH,
            ST_READ_LO: begin p.cs_n = 1'b0; p.byte_sel = 1'b1; end
            default:    ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/adc_pbr_timer.sv
module adc_pbr_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/adc_pbr_trigger.sv
module adc_pbr_trigger #(
    parameter int GAP_CYC    = 5000,
    parameter int PERIOD_CYC = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic auto_en_i,
    input  logic idle_i,
    output logic go_o
);
    localparam int GW = $clog2(GAP_CYC + 1);
    localparam int PW = $clog2(PERIOD_CYC + 1);

    logic          gap_ok;
    logic [PW-1:0] per_cnt;
    logic          tick;

    adc_pbr_timer #(.W(GW)) u_gap (
        .clk      (clk),
        .rst      (rst),
        .load     (go_o),
        .load_val (GW'(GAP_CYC - 1)),
        .zero     (gap_ok)
    );

    always_ff @(posedge clk) begin
        if (rst || !auto_en_i)
            per_cnt <= '0;
        else if (per_cnt == PW'(PERIOD_CYC - 1))
            per_cnt <= '0;
        else
            per_cnt <= per_cnt + 1'b1;
    end

    assign tick = auto_en_i && (per_cnt == PW'(PERIOD_CYC - 1));
    assign go_o = idle_i && gap_ok && (start_i || tick);

    // R7: no request accepted while the spacing window is open
    assert_gap_window_R7: assert property (@(posedge clk) disable iff (rst)
        go_o |=> !gap_ok);
endmodule

// File: rtl/adc_pbr_assemble.sv
module adc_pbr_assemble
    import adc_pbr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cap_hi,
    input  logic        cap_lo,
    input  logic [7:0]  bus_i,
    output pbr_sample_t sample_o
);
    logic [7:0] hi_q;
    logic       hi_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q     <= '0;
            hi_seen  <= 1'b0;
            sample_o <= '0;
        end else begin
            if (cap_hi) begin
                hi_q    <= bus_i;
                hi_seen <= 1'b1;
            end
            if (cap_lo) begin
                sample_o <= pbr_sample_t'({hi_q, bus_i});
                hi_seen  <= 1'b0;
            end
        end
    end

    // R5: lower byte is only combined after an upper byte was taken
    assert_lo_after_hi_R5: assert property (@(posedge clk) disable iff (rst)
        cap_lo |-> hi_seen);
endmodule

// File: rtl/adc_pbr_ctrl.sv
module adc_pbr_ctrl
    import adc_pbr_pkg::*;
#(
    parameter int PULSE_CYC   = 8,
    parameter int SETTLE_CYC  = 4,
    parameter int TIMEOUT_CYC = 4000,
    parameter int GAP_CYC     = 5000,
    parameter int PERIOD_CYC  = 10000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        auto_en_i,
    input  logic        adc_busy_i,
    input  logic [7:0]  adc_data_i,
    output logic        adc_cs_n_o,
    output logic        adc_rc_n_o,
    output logic        adc_byte_o,
    output logic [15:0] sample_o,
    output logic        sample_valid_o,
    output logic        timeout_err_o
);
    localparam int CW = $clog2(max3(PULSE_CYC, SETTLE_CYC, TIMEOUT_CYC) + 1);

    pbr_state_e  state, state_nx;
    pbr_pins_t   pins;
    pbr_sample_t sample;
    logic        busy_s1, busy_s2, busy_rise;
    logic        go, tmr_load, tmr_zero, cap_hi, cap_lo, err_set;
    logic [CW-1:0] tmr_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_s1 <= 1'b1;
            busy_s2 <= 1'b1;
        end else begin
            busy_s1 <= adc_busy_i;
            busy_s2 <= busy_s1;
        end
    end
    assign busy_rise = busy_s1 && !busy_s2;

    adc_pbr_trigger #(.GAP_CYC(GAP_CYC), .PERIOD_CYC(PERIOD_CYC)) u_trig (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .auto_en_i (auto_en_i),
        .idle_i    (state == ST_IDLE),
        .go_o      (go)
    );

    adc_pbr_timer #(.W(CW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap_hi   = 1'b0;
        cap_lo   = 1'b0;
        err_set  = 1'b0;
        case (state)
            ST_IDLE: if (go) begin
                state_nx = ST_CONV;
                tmr_load = 1'b1;
                tmr_val  = CW'(PULSE_CYC - 1);
            end
            ST_CONV: if (tmr_zero) begin
                state_nx = ST_WAIT_BUSY;
                tmr_load = 1'b1;
                tmr_val  = CW'(TIMEOUT_CYC - 1);
            end
            ST_WAIT_BUSY: begin
                if (busy_rise) begin
                    state_nx = ST_READ_HI;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(SETTLE_CYC);
                end else if (tmr_zero) begin
                    state_nx = ST_IDLE;
                    err_set  = 1'b1;
                end
            end
            ST_READ_HI: if (tmr_zero) begin
                state_nx = ST_SWITCH;
                cap_hi   = 1'b1;
            end
            ST_SWITCH: begin
                state_nx = ST_READ_LO;
                tmr_load = 1'b1;
                tmr_val  = CW'(SETTLE_CYC);
            end
            ST_READ_LO: if (tmr_zero) begin
                state_nx = ST_OUTPUT;
                cap_lo   = 1'b1;
            end
            ST_OUTPUT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            timeout_err_o <= 1'b0;
        end else begin
            state <= state_nx;
            if (err_set) timeout_err_o <= 1'b1;
        end
    end

    adc_pbr_assemble u_asm (
        .clk      (clk),
        .rst      (rst),
        .cap_hi   (cap_hi),
        .cap_lo   (cap_lo),
        .bus_i    (adc_data_i),
        .sample_o (sample)
    );

    assign pins           = pins_for(state);
    assign adc_cs_n_o     = pins.cs_n;
    assign adc_rc_n_o     = pins.rc_n;
    assign adc_byte_o     = pins.byte_sel;
    assign sample_o       = sample;
    assign sample_valid_o = (state == ST_OUTPUT);

    // R1: the convert pulse is never a single cycle when longer is asked
    assert_pulse_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (PULSE_CYC > 1 && $fell(adc_rc_n_o)) |=> !adc_rc_n_o);
    // R2: both lines released by the time busy rises
    assert_release_before_busy_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_busy_i) |-> (adc_rc_n_o && adc_cs_n_o));
    // R4: byte-select only goes high once the upper byte was read
    assert_byte_toggle_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_byte_o) |-> $past(state) == ST_READ_HI);
    // R5: valid strobe lasts one cycle
    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        sample_valid_o |=> !sample_valid_o);
    // R9: timeout flag is sticky
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        timeout_err_o |=> timeout_err_o);
endmodule

// File: tb/tb_adc_pbr_ctrl.sv
module tb_adc_pbr_ctrl;
    localparam int PULSE   = 8;
    localparam int SETTLE  = 3;
    localparam int TMO     = 200;
    localparam int GAP     = 400;
    localparam int PERIOD  = 600;
    localparam int CONV_T  = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, auto_en_i = 1'b0;
    logic busy = 1'b1;
    logic [7:0] bus;
    logic cs_n, rc_n, bsel, valid, err;
    logic [15:0] sample;

    always #2.5 clk = ~clk;

    adc_pbr_ctrl #(.PULSE_CYC(PULSE), .SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TMO),
                   .GAP_CYC(GAP), .PERIOD_CYC(PERIOD)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .auto_en_i(auto_en_i),
        .adc_busy_i(busy), .adc_data_i(bus), .adc_cs_n_o(cs_n),
        .adc_rc_n_o(rc_n), .adc_byte_o(bsel), .sample_o(sample),
        .sample_valid_o(valid), .timeout_err_o(err));

    int checks = 0, errors = 0;
    bit done = 0;

    // converter model
    logic [15:0] next_word = 16'h0000, cur_word = 16'h0000;
    bit dead = 0;
    int conv_left = 0;
    int stab = 0;
    logic [1:0] prev_sel = 2'b10;

    always @(negedge clk) begin
        if ({cs_n, bsel} != prev_sel) stab <= 0;
        else if (stab < 1000) stab <= stab + 1;
        prev_sel <= {cs_n, bsel};
        if (busy && !cs_n && !rc_n) begin
            busy      <= 1'b0;
            conv_left <= CONV_T;
            cur_word  <= next_word;
        end else if (!busy && !dead) begin
            if (conv_left == 0) busy <= 1'b1;
            else conv_left <= conv_left - 1;
        end
    end
    assign bus = (!cs_n && rc_n && stab >= SETTLE) ? (bsel ? cur_word[7:0] : cur_word[15:8]) : 8'hA5;

    // monitor
    int cyc = 0, rc_falls = 0, last_fall = -100000, min_space = 1000000;
    int low_run = 0, last_width = 0, valids = 0, bad_release = 0, double_valid = 0;
    logic prev_rc = 1'b1, prev_busy = 1'b1, prev_valid = 1'b0;
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (prev_rc && !rc_n) begin
                rc_falls <= rc_falls + 1;
                if (cyc - last_fall < min_space) min_space <= cyc - last_fall;
                last_fall <= cyc;
            end
            if (!rc_n) low_run <= low_run + 1;
            else if (!prev_rc) begin last_width <= low_run; low_run <= 0; end
            if (!prev_busy && busy && (!rc_n || !cs_n)) bad_release <= bad_release + 1;
            if (valid) valids <= valids + 1;
            if (valid && prev_valid) double_valid <= double_valid + 1;
        end
        prev_rc <= rc_n; prev_busy <= busy; prev_valid <= valid;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(posedge clk); #1 start_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0;
    endtask

    task automatic wait_valid(output bit got);
        got = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (valid) begin got = 1; break; end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(cs_n && rc_n && !bsel && !valid && !err, "R10 reset pins",
              {cs_n, rc_n, bsel, valid, err}, 5'b11000);
    endtask

    task automatic t_single(input logic [15:0] w);
        bit got;
        int f0, v0;
        next_word = w; f0 = rc_falls; v0 = valids;
        pulse_start();
        wait_valid(got);
        check(got, "R5 valid seen", got, 1);
        check($signed(sample) == $signed(w), "R3 R4 R5 sample", $signed(sample), $signed(w));
        check(last_width == PULSE, "R1 pulse width", last_width, PULSE);
        check(bad_release == 0, "R2 release before busy", bad_release, 0);
        @(negedge clk);
        check(!valid && sample == w, "R5 strobe one cycle, value held", valid, 0);
        check(rc_falls == f0 + 1 && valids == v0 + 1, "R6 one conversion", rc_falls - f0, 1);
        repeat (GAP) @(posedge clk);
    endtask

    task automatic t_busy_ignore();
        bit got;
        int f0;
        next_word = 16'h3C5A; f0 = rc_falls;
        pulse_start();
        while (busy) @(negedge clk);
        repeat (5) pulse_start();
        wait_valid(got);
        repeat (GAP + 20) @(negedge clk);
        check(rc_falls == f0 + 1, "R6 starts during busy ignored", rc_falls - f0, 1);
        check(sample == 16'h3C5A, "R6 sample", sample, 16'h3C5A);
    endtask

    task automatic t_gap();
        bit got;
        int f0;
        next_word = 16'h0102;
        pulse_start();
        wait_valid(got);
        f0 = rc_falls;
        pulse_start();
        repeat (60) @(negedge clk);
        check(rc_falls == f0, "R7 early start dropped", rc_falls - f0, 0);
        repeat (GAP) @(posedge clk);
        pulse_start();
        repeat (20) @(negedge clk);
        check(rc_falls == f0 + 1, "R7 start after gap", rc_falls - f0, 1);
        wait_valid(got);
        repeat (GAP) @(posedge clk);
    endtask

    task automatic t_auto();
        int f0;
        next_word = 16'h7FFF; f0 = rc_falls;
        @(posedge clk); #1 auto_en_i = 1'b1;
        repeat (3 * PERIOD + 100) @(negedge clk);
        #1 auto_en_i = 1'b0;
        check(rc_falls == f0 + 3, "R8 periodic conversions", rc_falls - f0, 3);
        repeat (GAP) @(negedge clk);
        check(sample == 16'h7FFF, "R8 periodic sample", sample, 16'h7FFF);
        check(min_space >= GAP, "R7 min spacing", min_space, GAP);
    endtask

    task automatic t_timeout();
        dead = 1;
        pulse_start();
        repeat (PULSE + TMO + 20) @(negedge clk);
        check(err == 1'b1, "R9 timeout flag", err, 1);
        check(cs_n && rc_n, "R9 back to idle", {cs_n, rc_n}, 2'b11);
        dead = 0;
        repeat (GAP) @(posedge clk);
        t_single(16'hC3E1);
        check(err == 1'b1, "R9 flag sticky", err, 1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_single(16'h1234);
        t_single(16'h8001);
        t_single(16'hFFFF);
        t_busy_ignore();
        t_gap();
        t_auto();
        t_timeout();
        check(double_valid == 0, "R5 no long strobe", double_valid, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule